// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller sits next to a small 8-bit processor core. Five request lines come straight from their sources: two external pins, two timer overflows and a serial-interface event. Six peripheral lines (A/D, time base, external peripheral, comparator, EEPROM, low-voltage detect) are gathered behind one shared multi-function source. Each request pulse is captured in a sticky flag. Each direct source has its own enable, and the multi-function source has one enable of its own. A master enable gates all of them.

Arbitration is tied to the core's instruction phase. Pending requests are examined only in a cycle where `phase_stb` is high. The highest-priority request that is both flagged and enabled wins. The controller then raises `svc_req` with a fixed vector address and holds both until the core answers with `svc_ack`. In the same grant it turns the master enable off; the core turns it back on with `reti` at the end of the handler. Software reaches flags and enables through a four-entry byte-wide register port with combinational read data.

Top module: `intc_vec_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `svc_req` is low.
- R2: Address 0 maps bit 0 to the master enable. Bits 1, 2 and 3 are the enables of external 0, external 1 and timer 0. Bits 4, 5 and 6 are the flags of the same three sources. Bit 7 reads 0. All seven bits are writable.
- R3: Address 1 holds the timer 1, serial and multi-function sources in the same pattern: enables in bits 1 to 3, flags in bits 4 to 6. Bits 0 and 7 read 0.
- R4: Address 2 bits 5:0 are the six sub-source enables and address 3 bits 5:0 are the six sub-source flags, in the order A/D, time base, external peripheral, comparator, EEPROM, low-voltage detect. Bits 7:6 read 0.
- R5: A one-cycle high on `core_req[i]` sets that source's flag whatever the enables say. The flag stays set until cleared.
- R6: A grant can only occur at a clock edge where `phase_stb` is high, and it uses the flags as they stood before that edge. A request that arrives in a strobe cycle is serviced at the next strobe.
- R7: A source is granted only when its flag, its own enable and the master enable are all set.
- R8: Priority from highest to lowest is external 0, external 1, timer 0, timer 1, serial, multi-function, with vectors 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R9: On a grant `svc_req` rises with the winner's vector. Both hold until `svc_ack`. The master enable and the winner's flag are cleared at the grant.
- R10: A sub-source pulse always sets its own flag. It sets the multi-function flag only if its sub-enable is set. Servicing the multi-function source clears the multi-function flag and leaves the sub-source flags untouched.
- R11: If a hardware request and a software write hit the same flag in the same cycle, the flag ends up set.
- R12: A `reti` pulse sets the master enable.
- R13: While `svc_req` is high no new grant occurs, even if the master enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_stb | input | 1 | Instruction-phase strobe that enables arbitration |
| core_req | input | 5 | Request pulses: ext0, ext1, timer0, timer1, serial (bit 0 up) |
| sub_req | input | 6 | Multi-function sub-source request pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| reti | input | 1 | Return-from-interrupt, sets master enable |
| svc_req | output | 1 | Service request to the core |
| svc_vector | output | 8 | Vector address of the granted source |
| svc_ack | input | 1 | Core acknowledge, drops `svc_req` |

## Verification
The assertions are checked on every cycle. They cover: a grant appears only after a strobe cycle and only while the master enable was set; the master enable reads clear after a grant; the request and its vector stay frozen until acknowledged; the vector is one of the six legal addresses; read bit 7 is always zero. Other behaviour can only be shown by the bench's scenarios, where a behavioural model runs alongside the design. These are: which source wins when several are pending, the one-strobe delay for a request arriving in a strobe cycle, the multi-function flag being cleared while sub-source flags persist, and a hardware set beating a simultaneous software clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int N_DIRECT   = 5;
  localparam int N_SUB      = 6;
  localparam int PER_REG    = 3;
  localparam int FLAG_LSB   = 4;
  localparam int EN_LSB     = 1;
  localparam int VEC_BASE   = 4;
  localparam int VEC_STEP   = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTL0   = 2'd0,
    SEL_CTL1   = 2'd1,
    SEL_SUBEN  = 2'd2,
    SEL_SUBFLG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_bit_bank.sv
// Bank of sticky control bits: hardware set wins, then hardware clear,
// then a per-bit software write.
module intc_bit_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] wd_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d, q_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign q_d[i] = set_i[i] ? 1'b1 :
                    clr_i[i] ? 1'b0 :
                    we_i[i]  ? wd_i[i] : q_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/intc_prio_arb.sv
// Fixed-priority pick: lowest index wins.
module intc_prio_arb #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [N-1:0]  win_oh_o,
  output logic [IW-1:0] win_idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign win_oh_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]    = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    win_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh_o[i]) win_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_svc_port.sv
// Holds the service request and vector until the core acknowledges.
module intc_svc_port #(
  parameter int N      = 6,
  parameter int IW     = $clog2(N),
  parameter int DW     = 8,
  parameter int V_BASE = 4,
  parameter int V_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [IW-1:0] idx_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [DW-1:0] vec_o
);
  logic          req_d, req_q;
  logic [DW-1:0] vec_d, vec_q;

  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    if (fire_i) begin
      req_d = 1'b1;
      vec_d = DW'(V_BASE + V_STEP * int'(idx_i));
    end else if (ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign req_o = req_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_DIRECT = N_DIRECT,
  parameter int NUM_SUB    = N_SUB,
  parameter int DW         = DATA_W,
  parameter int AW         = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phase_stb,
  input  logic [NUM_DIRECT-1:0] core_req,
  input  logic [NUM_SUB-1:0]    sub_req,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic                  reti,
  output logic                  svc_req,
  input  logic                  svc_ack,
  output logic [DW-1:0]         svc_vector
);
  localparam int NSRC   = NUM_DIRECT + 1;
  localparam int IW     = $clog2(NSRC);
  localparam int NGROUP = (NSRC + PER_REG - 1) / PER_REG;
  localparam int MF_IDX = NSRC - 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Register write decode
  logic [NGROUP-1:0] ctl_wr;
  logic              sub_en_wr, sub_flg_wr;
  always_comb begin
    ctl_wr     = '0;
    sub_en_wr  = 1'b0;
    sub_flg_wr = 1'b0;
    if (reg_we) begin
      unique case (reg_sel_e'(reg_addr))
        SEL_CTL0:   ctl_wr[0]  = 1'b1;
        SEL_CTL1:   ctl_wr[1]  = 1'b1;
        SEL_SUBEN:  sub_en_wr  = 1'b1;
        SEL_SUBFLG: sub_flg_wr = 1'b1;
        default: ;
      endcase
    end
  end

  // Per-source write steering: same bit pattern in each control register
  logic [NSRC-1:0] src_we, flg_wd, en_wd;
  for (genvar i = 0; i < NSRC; i++) begin : g_steer
    localparam int GRP = i / PER_REG;
    localparam int POS = i % PER_REG;
    assign src_we[i] = ctl_wr[GRP];
    assign flg_wd[i] = reg_wdata[FLAG_LSB + POS];
    assign en_wd[i]  = reg_wdata[EN_LSB + POS];
  end

  // Sub-sources
  logic [NUM_SUB-1:0] sub_en, sub_flg;
  intc_bit_bank #(.N(NUM_SUB)) u_sub_en (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i('0), .clr_i('0),
    .we_i({NUM_SUB{sub_en_wr}}), .wd_i(reg_wdata[NUM_SUB-1:0]),
    .q_o(sub_en)
  );
  intc_bit_bank #(.N(NUM_SUB)) u_sub_flg (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(sub_req), .clr_i('0),
    .we_i({NUM_SUB{sub_flg_wr}}), .wd_i(reg_wdata[NUM_SUB-1:0]),
    .q_o(sub_flg)
  );
  logic mf_hit;
  assign mf_hit = |(sub_req & sub_en);

  // Source flags and enables
  logic [NSRC-1:0] src_en, src_flg, src_set, src_clr;
  logic [NSRC-1:0] win_oh, pend;
  logic [IW-1:0]   win_idx;
  logic            any_pend, gie_q, gie_d, grant;

  assign src_set = {mf_hit, core_req};
  assign src_clr = grant ? win_oh : '0;

  intc_bit_bank #(.N(NSRC)) u_src_en (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i('0), .clr_i('0),
    .we_i(src_we), .wd_i(en_wd),
    .q_o(src_en)
  );
  intc_bit_bank #(.N(NSRC)) u_src_flg (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(src_set), .clr_i(src_clr),
    .we_i(src_we), .wd_i(flg_wd),
    .q_o(src_flg)
  );

  // Arbitration
  assign pend = src_flg & src_en & {NSRC{gie_q}};
  intc_prio_arb #(.N(NSRC)) u_arb (
    .req_i(pend), .any_o(any_pend),
    .win_oh_o(win_oh), .win_idx_o(win_idx)
  );
  assign grant = phase_stb & gie_q & ~svc_req & any_pend;

  // Master enable: grant clear beats reti, reti beats software write
  always_comb begin
    gie_d = gie_q;
    if (grant)          gie_d = 1'b0;
    else if (reti)      gie_d = 1'b1;
    else if (ctl_wr[0]) gie_d = reg_wdata[0];
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gie_q <= 1'b0;
    else             gie_q <= gie_d;
  end

  intc_svc_port #(
    .N(NSRC), .DW(DW), .V_BASE(VEC_BASE), .V_STEP(VEC_STEP)
  ) u_svc (
    .clk(clk), .rst_n(rst_sync_n),
    .fire_i(grant), .idx_i(win_idx), .ack_i(svc_ack),
    .req_o(svc_req), .vec_o(svc_vector)
  );

  // Readback
  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      SEL_CTL0:   reg_rdata = {1'b0, src_flg[PER_REG-1:0], src_en[PER_REG-1:0], gie_q};
      SEL_CTL1:   reg_rdata = {1'b0, src_flg[MF_IDX -: PER_REG],
                               src_en[MF_IDX -: PER_REG], 1'b0};
      SEL_SUBEN:  reg_rdata = DW'(sub_en);
      SEL_SUBFLG: reg_rdata = DW'(sub_flg);
      default: ;
    endcase
  end
endmodule

// File: rtl/intc_vec_ctrl_chk.sv
module intc_vec_ctrl_chk
  import intc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          phase_stb,
  input logic          svc_req,
  input logic          svc_ack,
  input logic [DW-1:0] svc_vector,
  input logic [DW-1:0] reg_rdata,
  input logic          gie
);
  localparam int VMAX = VEC_BASE + VEC_STEP * N_DIRECT;

  // R6: a grant follows only a strobe cycle
  a_r6_grant_on_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(svc_req) |-> $past(phase_stb));

  // R7: a grant needs the master enable
  a_r7_grant_needs_master: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(svc_req) |-> $past(gie));

  // R9: master enable cleared by the grant
  a_r9_master_cleared: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(svc_req) |-> !gie);

  // R9 and R13: request and vector frozen until acknowledge
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_sn)
    (svc_req && !svc_ack) |=> (svc_req && $stable(svc_vector)));

  // R8: only legal vector addresses
  a_r8_vector_legal: assert property (@(posedge clk) disable iff (!rst_sn)
    svc_req |-> (svc_vector[1:0] == 2'b00 && int'(svc_vector) >= VEC_BASE
                 && int'(svc_vector) <= VMAX));

  // R2: top bit of every register reads zero
  a_r2_msb_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    !reg_rdata[DW-1]);
endmodule

bind intc_vec_ctrl intc_vec_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_sn(rst_sync_n), .phase_stb(phase_stb),
  .svc_req(svc_req), .svc_ack(svc_ack), .svc_vector(svc_vector),
  .reg_rdata(reg_rdata), .gie(gie_q)
);

// File: tb/intc_vec_ctrl_tb.sv
`timescale 1ns/1ps
module intc_vec_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_stb = 1'b0;
  logic [4:0] core_req = '0;
  logic [5:0] sub_req = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reti = 1'b0;
  logic       svc_req;
  logic       svc_ack = 1'b0;
  logic [7:0] svc_vector;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb),
    .core_req(core_req), .sub_req(sub_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reti(reti),
    .svc_req(svc_req), .svc_ack(svc_ack), .svc_vector(svc_vector)
  );

  // Behavioural reference model
  int       rcnt;
  bit [5:0] m_flag, m_en, m_sen, m_sflg;
  bit       m_gie, m_svc;
  int       m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; m_flag = '0; m_en = '0; m_sen = '0; m_sflg = '0;
      m_gie = 0; m_svc = 0; m_vec = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      int  win;
      bit  fire;
      bit [5:0] pend;
      pend = m_flag & m_en;
      win = -1;
      for (int i = 5; i >= 0; i--) if (pend[i]) win = i;
      fire = phase_stb && m_gie && !m_svc && (win >= 0);
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin m_flag[2:0] = reg_wdata[6:4]; m_en[2:0] = reg_wdata[3:1]; m_gie = reg_wdata[0]; end
          2'd1: begin m_flag[5:3] = reg_wdata[6:4]; m_en[5:3] = reg_wdata[3:1]; end
          2'd2: m_sen = reg_wdata[5:0];
          default: m_sflg = reg_wdata[5:0];
        endcase
      end
      if (reti) m_gie = 1;
      if (fire) begin m_gie = 0; m_flag[win] = 0; end
      m_flag[4:0] = m_flag[4:0] | core_req;
      if ((sub_req & m_sen) != 0) m_flag[5] = 1;
      m_sflg = m_sflg | sub_req;
      if (fire) begin m_svc = 1; m_vec = 4 * (win + 1); end
      else if (svc_ack) m_svc = 0;
    end
  end

  function automatic bit [7:0] model_rd(input bit [1:0] a);
    case (a)
      2'd0: return {1'b0, m_flag[2:0], m_en[2:0], m_gie};
      2'd1: return {1'b0, m_flag[5:3], m_en[5:3], 1'b0};
      2'd2: return {2'b00, m_sen};
      default: return {2'b00, m_sflg};
    endcase
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(int'(svc_req), int'(m_svc), "R9 svc_req vs model");
      if (m_svc) chk(int'(svc_vector), m_vec, "R8 svc_vector vs model");
      chk(int'(reg_rdata), int'(model_rd(reg_addr)), "R2 reg_rdata vs model");
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cyc(); reg_we = 0;
  endtask
  task automatic rd(input bit [1:0] a, input int exp, input string tag);
    reg_addr = a; #1; chk(int'(reg_rdata), exp, tag);
  endtask
  task automatic pulse_core(input bit [4:0] v); core_req = v; cyc(); core_req = '0; endtask
  task automatic pulse_sub(input bit [5:0] v);  sub_req = v;  cyc(); sub_req = '0;  endtask
  task automatic strobe(); phase_stb = 1; cyc(); phase_stb = 0; endtask
  task automatic do_reti(); reti = 1; cyc(); reti = 0; endtask
  task automatic do_ack(); svc_ack = 1; cyc(); svc_ack = 0; endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    repeat (3) cyc();

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), 0, "R1 reset value");
    chk(int'(svc_req), 0, "R1 svc_req at reset");

    // R2 R3 R4 layouts
    wr(0, 8'hFF); rd(0, 8'h7F, "R2 ctl0 all ones");
    wr(0, 8'h00); rd(0, 8'h00, "R2 ctl0 cleared");
    wr(1, 8'hFF); rd(1, 8'h7E, "R3 ctl1 all ones");
    wr(1, 8'h00); rd(1, 8'h00, "R3 ctl1 cleared");
    wr(2, 8'hFF); rd(2, 8'h3F, "R4 sub enables");
    wr(3, 8'hFF); rd(3, 8'h3F, "R4 sub flags");
    wr(3, 8'h00); wr(2, 8'h00); rd(3, 8'h00, "R4 sub flags cleared");

    // R5 flag latch with enables off
    pulse_core(5'b00100); rd(0, 8'h40, "R5 timer0 flag latched");
    cyc(); rd(0, 8'h40, "R5 flag held");
    wr(0, 8'h00);

    // R7 enables required
    wr(0, 8'h01); pulse_core(5'b00010); strobe();
    chk(int'(svc_req), 0, "R7 no grant without source enable");
    rd(0, 8'h21, "R7 flag kept");
    wr(0, 8'h24); strobe();
    chk(int'(svc_req), 0, "R7 no grant without master enable");
    wr(0, 8'h00);

    // R6 request in strobe cycle waits for next strobe
    wr(0, 8'h0F);
    core_req = 5'b00001; phase_stb = 1; cyc(); core_req = '0; phase_stb = 0;
    chk(int'(svc_req), 0, "R6 same-cycle request not granted");
    rd(0, 8'h1F, "R6 flag pending");
    strobe();
    chk(int'(svc_req), 1, "R6 granted at next strobe");
    chk(int'(svc_vector), 8'h04, "R8 ext0 vector");
    rd(0, 8'h0E, "R9 flag and master cleared");
    cyc(); chk(int'(svc_req), 1, "R9 held without ack");
    do_ack(); chk(int'(svc_req), 0, "R9 dropped on ack");

    // R8 priority and R13 no regrant while outstanding
    wr(1, 8'h0E);
    pulse_core(5'b11010);
    rd(0, 8'h2E, "R5 ext1 flag");
    do_reti(); rd(0, 8'h2F, "R12 reti sets master");
    strobe(); chk(int'(svc_vector), 8'h08, "R8 ext1 over timer1/serial");
    do_reti(); strobe();
    chk(int'(svc_req), 1, "R13 still outstanding");
    chk(int'(svc_vector), 8'h08, "R13 vector unchanged");
    do_ack(); strobe();
    chk(int'(svc_vector), 8'h10, "R8 timer1 over serial");
    do_ack(); do_reti(); strobe();
    chk(int'(svc_vector), 8'h14, "R8 serial vector");
    do_ack(); do_reti();
    rd(1, 8'h0E, "R9 direct flags cleared");

    // R10 multi-function source
    wr(2, 8'h01);
    pulse_sub(6'b001000);
    rd(3, 8'h08, "R10 disabled sub flag set");
    rd(1, 8'h0E, "R10 disabled sub leaves shared flag");
    pulse_sub(6'b000001);
    rd(3, 8'h09, "R10 enabled sub flag set");
    rd(1, 8'h4E, "R10 shared flag set");
    strobe();
    chk(int'(svc_vector), 8'h18, "R10 shared vector");
    rd(1, 8'h0E, "R10 shared flag cleared by grant");
    rd(3, 8'h09, "R10 sub flags kept");
    do_ack();

    // R11 hardware set beats software write
    reg_we = 1; reg_addr = 0; reg_wdata = 8'h0E; core_req = 5'b00001;
    cyc(); reg_we = 0; core_req = '0;
    rd(0, 8'h1E, "R11 direct flag survives write");
    reg_we = 1; reg_addr = 3; reg_wdata = 8'h00; sub_req = 6'b000010;
    cyc(); reg_we = 0; sub_req = '0;
    rd(3, 8'h02, "R11 sub flag survives write");

    // R12 return re-enables service
    do_reti(); rd(0, 8'h1F, "R12 master set by reti");
    strobe(); chk(int'(svc_vector), 8'h04, "R12 service resumes");
    do_ack();
    repeat (4) cyc();
    finish_run();
  end
endmodule